// File: doc/BRIEF.md
# Four-Entry Branch Target Cache

This block sits beside the fetch stage of a pipelined processor and guesses where the instruction stream goes next. Every cycle the fetch stage presents its current program counter. The cache compares that address against the full address tag of all four entries in parallel, within the same cycle. On a match it returns the stored successor address. On no match it returns the sequential address, which is the program counter plus `STEP`.

A resolve port from the execute stage reports each branch once its outcome is known. The report carries the branch address, the taken flag, the real target, and whether the earlier guess was wrong. An update decoder turns each report into exactly one of four actions:

- `ACT_IDLE`: no change.
- `ACT_INSERT`: a taken branch that is not yet cached gets an entry.
- `ACT_REFRESH`: a correctly predicted taken branch rewrites its target and becomes most recently used.
- `ACT_DROP`: a cached branch whose guess was wrong is removed.

The decoder takes `ACT_INSERT` when a taken branch misses and `ACT_REFRESH` when a cached branch resolves taken and correct. It takes `ACT_DROP` when a cached branch resolves not-taken or mispredicted, and `ACT_IDLE` otherwise. Replacement uses a strict recency order across the four entries.

Top module: `btc_top`

## Requirements
- R1: After a synchronous reset every entry is invalid, every lookup misses, and the recency order is reset so that entry 0 is most recent and entry 3 is least recent.
- R2: A lookup that matches no valid entry drives `pred_hit` low and `pred_next_pc` to `fetch_pc + STEP` (STEP = 4), in the same cycle.
- R3: A resolved taken branch that is not cached is inserted. A later lookup of its address hits and returns the reported target.
- R4: A resolved not-taken branch that is cached is removed, so a later lookup of it misses. A not-taken branch that is not cached changes nothing.
- R5: A taken branch that is cached but reported as mispredicted is removed and not reinserted, so a later lookup of it misses.
- R6: Free entries are used before any valid entry is replaced, the lowest-numbered free entry first. Four distinct taken branches all stay resident.
- R7: When all four entries are valid, an insert replaces the least recently used entry. A lookup hit with `fetch_en` high, an insert and a refresh each make the entry most recent.
- R8: A taken, correctly predicted branch that is already cached rewrites its target in place. It allocates no second entry and evicts nothing.
- R9: When a resolve report and a lookup arrive in the same cycle, the report is applied first, so the lookup sees the updated contents.
- R10: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Lookup is a real fetch and counts as a use |
| fetch_pc | input | AW | Address being fetched |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_next_pc | output | AW | Predicted next fetch address |
| upd_en | input | 1 | Resolve report is valid this cycle |
| upd_pc | input | AW | Address of the resolved branch |
| upd_taken | input | 1 | Branch was taken |
| upd_target | input | AW | Actual successor address of the branch |
| upd_mispredict | input | 1 | Earlier prediction for this branch was wrong |

## Verification
The assertions assume that resolve reports are consistent with what the cache predicted:

- A taken branch that missed arrives flagged as mispredicted.
- A cached not-taken branch arrives flagged as mispredicted.
- A cached taken branch is flagged only when its real target differs from the stored one.

The stimulus derives the mispredict flag and the target from the bench's own model before each report, so every report keeps to these rules. The addresses come from a pool of eight, which forces frequent hits, replacements and collisions between lookups and updates.

// File: rtl/btc_pkg.sv
package btc_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_INSERT,
        ACT_REFRESH,
        ACT_DROP
    } upd_act_e;
endpackage

// File: rtl/btc_match.sv
module btc_match #(
    parameter int AW = 32,
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i]) idx = IW'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/btc_victim.sv
module btc_victim #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][IW-1:0] ages,
    output logic [IW-1:0]        idx
);
    logic [IW-1:0] free_idx;
    logic [IW-1:0] old_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IW'(i);
        end
        old_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (ages[i] == IW'(N - 1)) old_idx = IW'(i);
        end
    end

    assign idx = (&valid) ? old_idx : free_idx;
endmodule

// File: rtl/btc_lru.sv
module btc_lru #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ta_en,
    input  logic [IW-1:0]        ta_idx,
    input  logic                 tb_en,
    input  logic [IW-1:0]        tb_idx,
    output logic [N-1:0][IW-1:0] ages
);
    typedef logic [N-1:0][IW-1:0] age_t;

    age_t ages_q;
    age_t step_a;
    age_t step_b;

    function automatic age_t promote(input age_t a, input logic [IW-1:0] k);
        age_t r;
        r = a;
        for (int j = 0; j < N; j++) begin
            if (a[j] < a[k]) r[j] = a[j] + 1'b1;
        end
        r[k] = '0;
        return r;
    endfunction

    always_comb begin
        step_a = ta_en ? promote(ages_q, ta_idx) : ages_q;
        step_b = tb_en ? promote(step_a, tb_idx) : step_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ages_q[i] <= IW'(i);
        end else begin
            ages_q <= step_b;
        end
    end

    assign ages = ages_q;
endmodule

// File: rtl/btc_top.sv
module btc_top #(
    parameter int AW   = 32,
    parameter int N    = 4,
    parameter int STEP = 4,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_en,
    input  logic [AW-1:0] fetch_pc,
    output logic          pred_hit,
    output logic [AW-1:0] pred_next_pc,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_pc,
    input  logic          upd_taken,
    input  logic [AW-1:0] upd_target,
    input  logic          upd_mispredict
);
    import btc_pkg::*;

    logic [N-1:0]          valid_q,  nxt_valid;
    logic [N-1:0][AW-1:0]  tag_q,    nxt_tag;
    logic [N-1:0][AW-1:0]  tgt_q,    nxt_tgt;
    logic [N-1:0][IW-1:0]  ages_q;

    logic          u_hit;
    logic [IW-1:0] u_idx;
    logic [IW-1:0] vic_idx;
    logic [IW-1:0] slot;
    logic          l_hit;
    logic [IW-1:0] l_idx;
    upd_act_e      act;

    // Resolve-side match against the current contents.
    btc_match #(.AW(AW), .N(N)) u_match_upd (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (upd_pc),
        .hit   (u_hit),
        .idx   (u_idx)
    );

    btc_victim #(.N(N)) u_victim (
        .valid (valid_q),
        .ages  (ages_q),
        .idx   (vic_idx)
    );

    // Update decoder: one action per resolve report.
    always_comb begin
        act = ACT_IDLE;
        if (upd_en) begin
            if (u_hit)
                act = (upd_taken && !upd_mispredict) ? ACT_REFRESH : ACT_DROP;
            else if (upd_taken)
                act = ACT_INSERT;
        end
    end

    assign slot = (act == ACT_INSERT) ? vic_idx : u_idx;

    always_comb begin
        nxt_valid = valid_q;
        nxt_tag   = tag_q;
        nxt_tgt   = tgt_q;
        unique case (act)
            ACT_IDLE: ;
            ACT_INSERT: begin
                nxt_valid[slot] = 1'b1;
                nxt_tag[slot]   = upd_pc;
                nxt_tgt[slot]   = upd_target;
            end
            ACT_REFRESH: nxt_tgt[slot] = upd_target;
            ACT_DROP:    nxt_valid[slot] = 1'b0;
        endcase
    end

    // Fetch-side lookup sees the contents after this cycle's update.
    btc_match #(.AW(AW), .N(N)) u_match_fetch (
        .valid (nxt_valid),
        .tags  (nxt_tag),
        .key   (fetch_pc),
        .hit   (l_hit),
        .idx   (l_idx)
    );

    btc_lru #(.N(N)) u_lru (
        .clk    (clk),
        .rst    (rst),
        .ta_en  (act == ACT_INSERT || act == ACT_REFRESH),
        .ta_idx (slot),
        .tb_en  (fetch_en && l_hit),
        .tb_idx (l_idx),
        .ages   (ages_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            tag_q   <= '0;
            tgt_q   <= '0;
        end else begin
            valid_q <= nxt_valid;
            tag_q   <= nxt_tag;
            tgt_q   <= nxt_tgt;
        end
    end

    always_comb begin
        pred_hit     = l_hit;
        pred_next_pc = l_hit ? nxt_tgt[l_idx] : fetch_pc + AW'(STEP);
    end
endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
    parameter int AW = 32,
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 upd_en,
    input logic [AW-1:0]        upd_pc,
    input logic                 upd_taken,
    input logic                 upd_mispredict,
    input logic [N-1:0]         valid_q,
    input logic [N-1:0][AW-1:0] tag_q,
    input logic [N-1:0][IW-1:0] ages_q
);
    logic          dup;
    logic [N-1:0]  seen;
    logic          upd_present;
    logic          prev_present;
    logic [N-1:0]  low_free;
    logic [AW-1:0] upd_pc_d;

    always_ff @(posedge clk) upd_pc_d <= upd_pc;

    always_comb begin
        dup = 1'b0;
        seen = '0;
        upd_present = 1'b0;
        prev_present = 1'b0;
        low_free = '0;
        for (int i = 0; i < N; i++) begin
            seen[ages_q[i]] = 1'b1;
            if (valid_q[i] && tag_q[i] == upd_pc)   upd_present = 1'b1;
            if (valid_q[i] && tag_q[i] == upd_pc_d) prev_present = 1'b1;
            for (int j = i + 1; j < N; j++)
                if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
        end
        for (int i = N - 1; i >= 0; i--)
            if (!valid_q[i]) low_free = N'(1) << i;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> valid_q == '0);

    assert_insert_R3: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_taken && !upd_present |=> prev_present);

    assert_drop_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
        upd_en && !upd_taken |=> !prev_present);

    assert_drop_mispredict_R5: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_taken && upd_mispredict && upd_present |=> !prev_present);

    assert_fill_lowest_R6: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_taken && !upd_present && !(&valid_q)
        |=> valid_q == ($past(valid_q) | $past(low_free)));

    assert_lru_order_R7: assert property (@(posedge clk) disable iff (rst)
        &seen);

    assert_no_dup_tag_R10: assert property (@(posedge clk) disable iff (rst)
        !dup);
endmodule

bind btc_top btc_checker #(.AW(AW), .N(N)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .upd_en         (upd_en),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_mispredict (upd_mispredict),
    .valid_q        (valid_q),
    .tag_q          (tag_q),
    .ages_q         (ages_q)
);

// File: tb/btc_top_test.sv
module btc_top_test;
    localparam int AW = 32;
    localparam int N  = 4;
    localparam int STEP = 4;

    logic          clk = 0;
    logic          rst = 1;
    logic          fetch_en = 0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_hit;
    logic [AW-1:0] pred_next_pc;
    logic          upd_en = 0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_mispredict = 0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference: list ordered most recent first.
    logic [AW-1:0] m_tag[$];
    logic [AW-1:0] m_tgt[$];

    btc_top #(.AW(AW), .N(N), .STEP(STEP)) uut (.*);

    always #5 clk = ~clk;

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < m_tag.size(); i++) if (m_tag[i] == a) return i;
        return -1;
    endfunction

    task automatic m_front(input logic [AW-1:0] a, input logic [AW-1:0] t);
        m_tag.push_front(a);
        m_tgt.push_front(t);
    endtask

    task automatic m_remove(input int k);
        m_tag.delete(k);
        m_tgt.delete(k);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // One cycle: drive, apply the model update, compare the lookup.
    task automatic step(input string req, input bit fe, input logic [AW-1:0] fpc,
                        input bit ue, input logic [AW-1:0] upc, input bit utk,
                        input logic [AW-1:0] utgt, input bit umis);
        int k;
        bit e_hit;
        logic [AW-1:0] e_next;
        @(negedge clk);
        fetch_en = fe; fetch_pc = fpc;
        upd_en = ue; upd_pc = upc; upd_taken = utk;
        upd_target = utgt; upd_mispredict = umis;
        k = m_find(upc);
        if (ue) begin
            if (k >= 0) begin
                m_remove(k);
                if (utk && !umis) m_front(upc, utgt);
            end else if (utk) begin
                if (m_tag.size() == N) m_remove(N - 1);
                m_front(upc, utgt);
            end
        end
        k = m_find(fpc);
        e_hit = (k >= 0);
        e_next = e_hit ? m_tgt[k] : fpc + AW'(STEP);
        #1;
        checks++;
        if (pred_hit !== e_hit || pred_next_pc !== e_next) begin
            fails++;
            $display("FAIL %s pc=%h hit=%0b next=%h expected hit=%0b next=%h",
                     req, fpc, pred_hit, pred_next_pc, e_hit, e_next);
        end
        if (fe && e_hit) begin
            logic [AW-1:0] tt;
            tt = m_tgt[k];
            m_remove(k);
            m_front(fpc, tt);
        end
    endtask

    task automatic look(input string req, input logic [AW-1:0] a);
        step(req, 1'b0, a, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic touch(input string req, input logic [AW-1:0] a);
        step(req, 1'b1, a, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic report(input string req, input logic [AW-1:0] a, input bit tk,
                          input logic [AW-1:0] t, input bit mis);
        step(req, 1'b0, 32'hFFF0, 1'b1, a, tk, t, mis);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [AW-1:0] A = 32'h100, B = 32'h104, C = 32'h108,
                              D = 32'h10C, E = 32'h110;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 / R2: empty after reset, sequential successor
        look("R1", A);
        look("R2", 32'h2000);
        // R3 insert, then hit
        report("R3", A, 1'b1, 32'h4000, 1'b1);
        look("R3", A);
        // R9 update and lookup of the same address in one cycle
        step("R9", 1'b1, B, 1'b1, B, 1'b1, 32'h5000, 1'b1);
        // R4 not-taken on a cached branch removes it
        report("R4", B, 1'b0, B + 4, 1'b1);
        look("R4", B);
        // R4 not-taken on an uncached branch: A unchanged
        report("R4", C, 1'b0, C + 4, 1'b0);
        look("R4", A);
        look("R4", C);
        // R5 mispredicted taken on a cached branch removes it
        report("R5", A, 1'b1, 32'h4400, 1'b1);
        look("R5", A);
        // R6 four distinct taken branches all resident
        report("R6", A, 1'b1, 32'h6000, 1'b1);
        report("R6", B, 1'b1, 32'h6100, 1'b1);
        report("R6", C, 1'b1, 32'h6200, 1'b1);
        report("R6", D, 1'b1, 32'h6300, 1'b1);
        look("R6", A); look("R6", B); look("R6", C); look("R6", D);
        // R8 correct refresh on B: no new allocation
        report("R8", B, 1'b1, 32'h6100, 1'b0);
        look("R8", A); look("R8", C); look("R8", D);
        // R7 touching A, then E evicts the least recent (C)
        touch("R7", A);
        report("R7", E, 1'b1, 32'h7000, 1'b1);
        look("R7", C); look("R7", A); look("R7", B); look("R7", E);
        // R10 and random mix
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] ua, fa, tg;
            bit tk, mis;
            int k;
            ua = 32'h100 + 4 * ($urandom % 8);
            fa = 32'h100 + 4 * ($urandom % 8);
            tk = $urandom % 3 != 0;
            k = m_find(ua);
            tg = 32'h8000 + 4 * ($urandom % 64);
            if (k >= 0 && tk) begin
                if ($urandom % 2 != 0) tg = m_tgt[k];
                mis = (tg != m_tgt[k]);
            end else if (k >= 0) begin
                mis = 1'b1;
            end else begin
                mis = tk;
            end
            step("R10", ($urandom % 5) != 0, fa, ($urandom % 3) != 0, ua, tk, tg, mis);
        end
        finish_run();
    end
endmodule